// File: doc/BRIEF.md
# Flash Command Gating and Ready/Busy Front End

This block sits at the command port of a parallel NOR-style flash. It samples the chip-select, write-strobe and output-strobe inputs once per clock, using the system clock. It accepts a write cycle only when the strobe levels are legal and the active phase is long enough. It commits the cycle when the strobes are released. The block then walks the committed address/data pairs through the unlock handshake that introduces a program or an erase. A correct final cycle starts a modelled embedded operation. That operation is a down-counter of programmable length.

Progress is reported on an open-drain ready/busy line. The block only gives a pull-down enable. The line is high-impedance otherwise, so several devices can share one pulled-up wire as a wired-AND. Three inputs keep stray activity out of the command register and the operation engine:

- a low-supply lockout input;
- a hardware reset input;
- a power-up guard that discards the first strobe release if the strobes were already active while the block came out of reset.

An erase can be suspended and resumed without losing its progress.

Top module: `flash_cmd_front`

## Requirements
- R1: A write cycle is taken only when ce_n=0, we_n=0 and oe_n=1 hold together for at least GLITCH_CYC consecutive clock samples. It is committed when that condition ends, using the last address/data seen while it held. Shorter pulses, and any cycle with oe_n low, are dropped.
- R2: Program sequence, at default keys: (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), then any address/data. The pull-down enable rises on the second clock edge after the release of the fourth cycle.
- R3: Erase sequence: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), then any address with data 0x30. Busy rises on the second clock edge after the release of the sixth cycle.
- R4: A cycle that does not match the expected pair sends the sequencer back to its first step. No busy is raised, and the mismatching cycle is not reused as a first step.
- R5: A program keeps busy for exactly PROG_CYCLES clocks, and an erase for ERASE_CYCLES clocks of active counting. After that the block is ready, and op_mode reads 0 (read) on the following clock.
- R6: While a program or erase runs, every other command cycle is discarded. It neither lengthens the running operation nor starts a new one afterwards.
- R7: A cycle with data 0xB0 during an erase suspends it: op_mode=3, the line is released and the remaining count is frozen. A cycle with data 0x30 while suspended resumes the erase with the frozen count.
- R8: While dev_rst_n is low the pull-down enable is active. On the next clock edge the engine and the sequencer return to read mode (op_mode=0).
- R9: While supply_low is high, any operation is aborted to read mode on the next edge and all write cycles are ignored. Normal acceptance returns once it clears.
- R10: If ce_n=0, we_n=0 and oe_n=1 are already present when rst_n is released, the first release of that strobe is not committed as a command cycle.
- R11: op_mode encodes 0 read, 1 program, 2 erase, 3 suspended. The pull-down enable is low in read, suspended and standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| dev_rst_n | input | 1 | Hardware reset, active low |
| supply_low | input | 1 | Low-supply lockout, active high |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | AW | Command address |
| data | input | DW | Command data |
| rb_pull_low | output | 1 | Open-drain ready/busy pull-down enable (1 = drive low) |
| op_mode | output | 2 | Current operating mode |

## Verification
A sequencer left in a wrong step shows up at the first committed cycle that should have completed a sequence. Busy then fails to rise two clocks after that release, or it rises after a cycle that should have been a mismatch. An engine counter that is loaded wrongly, or that keeps counting when frozen, shows as busy ending one or more clocks away from the computed edge. For a suspended erase this appears only after the resume, when the remaining time is measured against the count frozen at suspend. A lost power-up guard or lockout gate shows as a busy pulse after a sequence that should have been incomplete.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_PROG  = 2'd1,
    MD_ERASE = 2'd2,
    MD_SUSP  = 2'd3
  } op_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_UNL1 = 3'd1,
    SQ_UNL2 = 3'd2,
    SQ_PROG = 3'd3,
    SQ_ER1  = 3'd4,
    SQ_ER2  = 3'd5,
    SQ_ER3  = 3'd6
  } seq_step_e;

endpackage

// File: rtl/strobe_filter.sv
module strobe_filter #(
  parameter int GLITCH_CYC = 3,
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          block,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  localparam int CW = $clog2(GLITCH_CYC + 1);

  logic          raw_act;
  logic          qual;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;
  logic          evt_q, evt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign raw_act = ~ce_n & ~we_n & oe_n;
  assign qual    = (cnt_q == CW'(GLITCH_CYC));

  always_comb begin
    cnt_d   = cnt_q;
    if (raw_act) begin
      if (!qual) cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = '0;
    end
    armed_d = armed_q | ~raw_act;
    evt_d   = ~raw_act & qual & armed_q & ~block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (raw_act) begin
      addr_q <= addr;
      data_q <= data;
    end
  end

  assign wr_evt  = evt_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  assert_evt_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);

  assert_first_edge_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !evt_q);

endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
  import flash_cmd_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_A    = 12'h555,
  parameter logic [AW-1:0] ADDR_B    = 12'h2AA,
  parameter logic [DW-1:0] KEY_A     = 8'hAA,
  parameter logic [DW-1:0] KEY_B     = 8'h55,
  parameter logic [DW-1:0] KEY_PROG  = 8'hA0,
  parameter logic [DW-1:0] KEY_ERASE = 8'h80,
  parameter logic [DW-1:0] KEY_GO    = 8'h30,
  parameter logic [DW-1:0] KEY_SUSP  = 8'hB0,
  parameter logic [DW-1:0] KEY_RES   = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  op_mode_e      mode,
  output logic          start_prog,
  output logic          start_erase,
  output logic          susp_req,
  output logic          resume_req
);

  seq_step_e step_q, step_d;
  logic      hit_a, hit_b;

  assign hit_a = (wr_addr == ADDR_A) && (wr_data == KEY_A);
  assign hit_b = (wr_addr == ADDR_B) && (wr_data == KEY_B);

  always_comb begin
    step_d      = step_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    susp_req    = 1'b0;
    resume_req  = 1'b0;
    if (clear) begin
      step_d = SQ_IDLE;
    end else if (mode != MD_READ) begin
      step_d = SQ_IDLE;
      if (wr_evt) begin
        susp_req   = (mode == MD_ERASE) && (wr_data == KEY_SUSP);
        resume_req = (mode == MD_SUSP)  && (wr_data == KEY_RES);
      end
    end else if (wr_evt) begin
      step_d = SQ_IDLE;
      unique case (step_q)
        SQ_IDLE: if (hit_a) step_d = SQ_UNL1;
        SQ_UNL1: if (hit_b) step_d = SQ_UNL2;
        SQ_UNL2: begin
          if (wr_addr == ADDR_A && wr_data == KEY_PROG)       step_d = SQ_PROG;
          else if (wr_addr == ADDR_A && wr_data == KEY_ERASE) step_d = SQ_ER1;
        end
        SQ_PROG: start_prog = 1'b1;
        SQ_ER1:  if (hit_a) step_d = SQ_ER2;
        SQ_ER2:  if (hit_b) step_d = SQ_ER3;
        SQ_ER3:  start_erase = (wr_data == KEY_GO);
        default: step_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= SQ_IDLE;
    else        step_q <= step_d;
  end

  assert_start_only_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> (mode == MD_READ));

  assert_mismatch_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && step_q == SQ_UNL1 && !hit_b && !clear) |=> (step_q == SQ_IDLE));

endmodule

// File: rtl/op_engine.sv
module op_engine
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 40
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     abort,
  input  logic     start_prog,
  input  logic     start_erase,
  input  logic     susp_req,
  input  logic     resume_req,
  output op_mode_e mode,
  output logic     busy
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  op_mode_e      mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == CW'(1));

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (abort) begin
      mode_d = MD_READ;
      cnt_d  = '0;
    end else begin
      unique case (mode_q)
        MD_READ: begin
          if (start_prog) begin
            mode_d = MD_PROG;
            cnt_d  = CW'(PROG_CYCLES);
          end else if (start_erase) begin
            mode_d = MD_ERASE;
            cnt_d  = CW'(ERASE_CYCLES);
          end
        end
        MD_PROG: begin
          if (last) begin
            mode_d = MD_READ;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        MD_ERASE: begin
          if (susp_req) begin
            mode_d = MD_SUSP;
          end else if (last) begin
            mode_d = MD_READ;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q - CW'(1);
          end
        end
        MD_SUSP: if (resume_req) mode_d = MD_ERASE;
        default: mode_d = MD_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode = mode_q;
  assign busy = (mode_q == MD_PROG) || (mode_q == MD_ERASE);

  assert_prog_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PROG) |=> (mode_q == MD_PROG || mode_q == MD_READ));

  assert_busy_count_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0));

  assert_suspend_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SUSP && !resume_req && !abort) |=> (mode_q == MD_SUSP && $stable(cnt_q)));

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int AW           = 12,
  parameter int DW           = 8,
  parameter int GLITCH_CYC   = 3,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dev_rst_n,
  input  logic          supply_low,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          rb_pull_low,
  output logic [1:0]    op_mode
);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          block;
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          start_prog, start_erase, susp_req, resume_req;
  op_mode_e      mode_w;
  logic          busy_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign block = supply_low | ~dev_rst_n;

  strobe_filter #(.GLITCH_CYC(GLITCH_CYC), .AW(AW), .DW(DW)) u_filter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr    (addr),
    .data    (data),
    .block   (block),
    .wr_evt  (wr_evt),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  cmd_sequencer #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .clear       (block),
    .wr_evt      (wr_evt),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .mode        (mode_w),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .susp_req    (susp_req),
    .resume_req  (resume_req)
  );

  op_engine #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_eng (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .abort       (block),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .susp_req    (susp_req),
    .resume_req  (resume_req),
    .mode        (mode_w),
    .busy        (busy_w)
  );

  assign rb_pull_low = busy_w | ~dev_rst_n;
  assign op_mode     = mode_w;

  assert_lockout_to_read_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    supply_low |=> (op_mode == 2'd0));

  assert_devrst_to_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !dev_rst_n |=> (op_mode == 2'd0));

  assert_suspend_ready_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_mode == 2'd3 && dev_rst_n) |-> !rb_pull_low);

endmodule

// File: tb/flash_cmd_front_tb.sv
module flash_cmd_front_tb_top;

  localparam int AW = 12;
  localparam int DW = 8;
  localparam int GC = 3;
  localparam int PC = 20;
  localparam int EC = 40;

  logic          clk = 1'b0;
  logic          rst_n, dev_rst_n, supply_low, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          rb_pull_low;
  logic [1:0]    op_mode;
  wire           rb_line = ~rb_pull_low;   // bench pull-up on the shared wire

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  flash_cmd_front #(.AW(AW), .DW(DW), .GLITCH_CYC(GC), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .supply_low(supply_low),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .data(data),
    .rb_pull_low(rb_pull_low), .op_mode(op_mode)
  );

  typedef struct packed {
    logic [11:0] a;
    logic [7:0]  d;
    logic [3:0]  hold;
    logic        busy;
    logic [1:0]  mode;
    logic [7:0]  settle;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{12'h555, 8'hAA, 4'd3, 1'b0, 2'd0, 8'd0},   // R2 program
    '{12'h2AA, 8'h55, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h555, 8'hA0, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h123, 8'h5A, 4'd3, 1'b1, 2'd1, 8'd25},
    '{12'h555, 8'hAA, 4'd3, 1'b0, 2'd0, 8'd0},   // R3 erase
    '{12'h2AA, 8'h55, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h555, 8'h80, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h555, 8'hAA, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h2AA, 8'h55, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h040, 8'h30, 4'd3, 1'b1, 2'd2, 8'd45},
    '{12'h555, 8'hAA, 4'd3, 1'b0, 2'd0, 8'd0},   // R4 mismatch
    '{12'h2AA, 8'h77, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h555, 8'hA0, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h111, 8'h22, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h555, 8'hAA, 4'd2, 1'b0, 2'd0, 8'd0},   // R1 short pulse dropped
    '{12'h2AA, 8'h55, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h555, 8'hA0, 4'd3, 1'b0, 2'd0, 8'd0},
    '{12'h100, 8'h11, 4'd3, 1'b0, 2'd0, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one write cycle; returns at the sample point two edges after release
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold, input logic oe);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe;
    repeat (hold) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic seq_prog();
    wr(12'h555, 8'hAA, GC, 1'b1);
    wr(12'h2AA, 8'h55, GC, 1'b1);
    wr(12'h555, 8'hA0, GC, 1'b1);
    wr(12'h3C3, 8'h12, GC, 1'b1);
  endtask

  task automatic seq_erase();
    wr(12'h555, 8'hAA, GC, 1'b1);
    wr(12'h2AA, 8'h55, GC, 1'b1);
    wr(12'h555, 8'h80, GC, 1'b1);
    wr(12'h555, 8'hAA, GC, 1'b1);
    wr(12'h2AA, 8'h55, GC, 1'b1);
    wr(12'h080, 8'h30, GC, 1'b1);
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (rb_pull_low && k < 300) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int k;
    rst_n = 1'b0; dev_rst_n = 1'b1; supply_low = 1'b0;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset ready", rb_pull_low, 0);
    chk("R11 reset mode", op_mode, 0);
    chk("R11 line high", rb_line, 1);

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d, int'(VECS[i].hold), 1'b1);
      chk($sformatf("R2/R3/R4/R1 vec%0d busy", i), rb_pull_low, VECS[i].busy);
      chk($sformatf("R2/R3/R4/R1 vec%0d mode", i), op_mode, VECS[i].mode);
      repeat (int'(VECS[i].settle)) @(negedge clk);
    end

    // R1: output strobe low inhibits the cycle
    wr(12'h555, 8'hAA, GC, 1'b0);
    wr(12'h2AA, 8'h55, GC, 1'b1);
    wr(12'h555, 8'hA0, GC, 1'b1);
    wr(12'h100, 8'h11, GC, 1'b1);
    chk("R1 oe low inhibits", rb_pull_low, 0);

    // R5: exact program length
    seq_prog();
    chk("R2 busy after 4th", rb_pull_low, 1);
    repeat (PC - 1) @(negedge clk);
    chk("R5 still busy at last clk", rb_pull_low, 1);
    @(negedge clk);
    chk("R5 ready after PROG_CYCLES", rb_pull_low, 0);
    chk("R5 back to read", op_mode, 0);

    // R6: commands during erase are discarded
    seq_erase();
    chk("R3 busy after 6th", rb_pull_low, 1);
    seq_prog();
    chk("R6 mode stays erase", op_mode, 2);
    wait_ready(k);
    chk("R6 erase length unchanged", 20 + k, EC);
    repeat (5) @(negedge clk);
    chk("R6 no deferred program", rb_pull_low, 0);

    // R7: suspend and resume
    seq_erase();
    repeat (5) @(negedge clk);
    wr(12'h000, 8'hB0, GC, 1'b1);
    chk("R7 suspended mode", op_mode, 3);
    chk("R7 ready while suspended", rb_pull_low, 0);
    repeat (30) @(negedge clk);
    chk("R7 suspend holds", op_mode, 3);
    wr(12'h000, 8'h30, GC, 1'b1);
    chk("R7 resumed busy", rb_pull_low, 1);
    wait_ready(k);
    chk("R7 remaining count", k, EC - 9);

    // R8: hardware reset
    dev_rst_n = 1'b0;
    @(negedge clk);
    chk("R8 busy during reset idle", rb_pull_low, 1);
    dev_rst_n = 1'b1;
    @(negedge clk);
    seq_prog();
    dev_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 busy during reset", rb_pull_low, 1);
    dev_rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ready after reset", rb_pull_low, 0);
    chk("R8 read after reset", op_mode, 0);

    // R9: supply lockout
    seq_erase();
    supply_low = 1'b1;
    @(negedge clk);
    chk("R9 abort to read", op_mode, 0);
    chk("R9 ready on abort", rb_pull_low, 0);
    seq_prog();
    chk("R9 writes ignored", rb_pull_low, 0);
    supply_low = 1'b0;
    @(negedge clk);
    seq_prog();
    chk("R9 accepts after clear", rb_pull_low, 1);
    wait_ready(k);

    // R10: strobe active across power-up
    rst_n = 1'b0;
    addr = 12'h555; data = 8'hAA; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (2) @(negedge clk);
    wr(12'h2AA, 8'h55, GC, 1'b1);
    wr(12'h555, 8'hA0, GC, 1'b1);
    wr(12'h100, 8'h11, GC, 1'b1);
    chk("R10 first edge discarded", rb_pull_low, 0);
    seq_prog();
    chk("R10 later cycles accepted", rb_pull_low, 1);
    wait_ready(k);

    finish_run();
  end

endmodule